// File: doc/BRIEF.md
# Converter Parallel Readout Port

This block is the parallel output stage of a 16-bit data converter. A small sequencer runs each conversion. A start pulse captures the raw sample and raises `busy_o` for a fixed number of clocks. When `busy_o` drops, the output register takes the new result. The host reads that register over a tri-stated data bus. The bus is gated by active-low chip-select and read strobes, and by a serial/parallel mode select.

Two inputs change the presented word without touching the stored result. A coding select gives either straight offset binary or twos complement. A lane-swap input exchanges the two bytes, so an 8-bit host can read the word as two bytes on one lane by toggling the swap input like an address line.

Reads may happen in the acquisition gap after a conversion, or during the next conversion. During a conversion the previous complete result is presented.

Top module: `adc_pread_port`

## Requirements
- R1: `bus_o` is high impedance and `drive_o` is 0 whenever `cs_n_i` or `rd_n_i` is 1. The bus drives, with `drive_o` = 1, only when both strobes are 0 and `ser_sel_i` is 0.
- R2: While `ser_sel_i` is 1 (serial mode), the parallel bus stays high impedance whatever the strobes are.
- R3: A `start_i` sampled while idle raises `busy_o` at that clock edge. `busy_o` then stays high for exactly `CONV_CYCLES` clock cycles.
- R4: A `start_i` pulse during a conversion is ignored. It neither extends nor restarts the conversion, and its `sample_i` value is never presented.
- R5: `sample_i` is captured at the edge that starts the conversion. The output register loads that value at the same edge where `busy_o` falls.
- R6: A read during a conversion returns the complete previous result.
- R7: With `swap_i` = 0, coded word bits [7:0] appear on `bus_o[7:0]` and bits [15:8] appear on `bus_o[15:8]`.
- R8: With `swap_i` = 1, the lanes are exchanged: coded bits [7:0] appear on `bus_o[15:8]` and coded bits [15:8] appear on `bus_o[7:0]`.
- R9: With `twos_i` = 0 the coded word equals the raw straight-binary result. With `twos_i` = 1 the coded word is the raw result with bit 15 inverted.
- R10: After reset `busy_o` is 0 and the stored result is zero. A read then shows 0x0000 in straight binary and 0x8000 in twos complement.
- R11: With both strobes held low across a conversion, the bus keeps the previous data and changes to the new result only when `busy_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion start request |
| sample_i | input | 16 | Raw straight-binary conversion value |
| ser_sel_i | input | 1 | 1 = serial mode, parallel bus disabled |
| cs_n_i | input | 1 | Active-low chip select |
| rd_n_i | input | 1 | Active-low read strobe |
| swap_i | input | 1 | Byte-lane exchange |
| twos_i | input | 1 | 1 = twos complement coding |
| busy_o | output | 1 | Conversion in progress |
| drive_o | output | 1 | Bus pins actively driven |
| bus_o | output | 16 | Tri-stated data bus |

## Verification
The embedded assertions check the per-cycle invariants on every cycle:
- the bus is released when a strobe or the mode select forbids driving;
- busy rises only in answer to a start and holds through the conversion;
- the result register changes only on its load edge, and then to the captured sample;
- with controls steady, the driven bus changes only when busy falls;
- the MSB inversion and the lane exchange hold.

Only the bench's scenarios can show the rest: the exact length of a conversion, that a start during a busy period is ignored, reads at different points of a conversion, and the full coded value for each combination of lane order and coding.

// File: rtl/adc_pread_pkg.sv
package adc_pread_pkg;
    // Output coding selected by the host.
    typedef enum logic {
        CODE_STRAIGHT = 1'b0,
        CODE_TWOS     = 1'b1
    } code_e;

    // Apply the output coding to a raw straight-binary word.
    function automatic logic [15:0] apply_code16(input logic [15:0] raw, input code_e mode);
        apply_code16 = (mode == CODE_TWOS) ? {~raw[15], raw[14:0]} : raw;
    endfunction
endpackage

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int WIDTH       = 16,
    parameter int CONV_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] sample_i,
    output logic             busy_o,
    output logic             finish_o,
    output logic [WIDTH-1:0] hold_o
);
    localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        logic [WIDTH-1:0] hold;
    } seq_t;

    seq_t seq_d, seq_q;
    logic finish;

    always_comb begin
        seq_d  = seq_q;
        finish = seq_q.busy && (seq_q.cnt == LAST);
        if (!seq_q.busy) begin
            if (start_i) begin
                seq_d.busy = 1'b1;
                seq_d.cnt  = '0;
                seq_d.hold = sample_i;
            end
        end else if (finish) begin
            seq_d.busy = 1'b0;
        end else begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o   = seq_q.busy;
    assign finish_o = finish;
    assign hold_o   = seq_q.hold;

    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.busy) |-> $past(start_i));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && !finish) |=> (seq_q.busy && $stable(seq_q.hold)));
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] res_o
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (load_i) res_d.res = din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_o = res_q.res;

    // R5
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (res_q.res == $past(din_i)));

    // R6
    res_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(res_q.res));
endmodule

// File: rtl/adc_bus_lane.sv
module adc_bus_lane
    import adc_pread_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] res_i,
    input  logic             swap_i,
    input  logic             twos_i,
    input  logic             cs_n_i,
    input  logic             rd_n_i,
    input  logic             ser_sel_i,
    output logic             drive_o,
    output logic [WIDTH-1:0] bus_o
);
    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] coded;
    logic [WIDTH-1:0] laned;
    logic             enable;

    always_comb begin
        coded = twos_i ? {~res_i[WIDTH-1], res_i[WIDTH-2:0]} : res_i;
    end

    for (genvar b = 0; b < HALF; b++) begin : g_lane
        assign laned[b]        = swap_i ? coded[b + HALF] : coded[b];
        assign laned[b + HALF] = swap_i ? coded[b]        : coded[b + HALF];
    end

    assign enable  = !ser_sel_i && !cs_n_i && !rd_n_i;
    assign drive_o = enable;
    assign bus_o   = enable ? laned : {WIDTH{1'bz}};

    // R1
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i || rd_n_i) |-> !drive_o);

    // R2
    serial_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sel_i |-> !drive_o);

    // R9
    msb_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o && twos_i && !swap_i) |-> (bus_o[WIDTH-1] != res_i[WIDTH-1]));

    // R8
    lane_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o && swap_i && !twos_i) |-> (bus_o[HALF-1:0] == res_i[WIDTH-1:HALF]));
endmodule

// File: rtl/adc_pread_port.sv
module adc_pread_port #(
    parameter int WIDTH       = 16,
    parameter int CONV_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] sample_i,
    input  logic             ser_sel_i,
    input  logic             cs_n_i,
    input  logic             rd_n_i,
    input  logic             swap_i,
    input  logic             twos_i,
    output logic             busy_o,
    output logic             drive_o,
    output logic [WIDTH-1:0] bus_o
);
    logic             finish;
    logic [WIDTH-1:0] hold;
    logic [WIDTH-1:0] res;

    adc_conv_seq #(.WIDTH(WIDTH), .CONV_CYCLES(CONV_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_i(sample_i),
        .busy_o(busy_o), .finish_o(finish), .hold_o(hold)
    );

    adc_result_reg #(.WIDTH(WIDTH)) u_res (
        .clk(clk), .rst_n(rst_n), .load_i(finish), .din_i(hold), .res_o(res)
    );

    adc_bus_lane #(.WIDTH(WIDTH)) u_lane (
        .clk(clk), .rst_n(rst_n), .res_i(res), .swap_i(swap_i), .twos_i(twos_i),
        .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .ser_sel_i(ser_sel_i),
        .drive_o(drive_o), .bus_o(bus_o)
    );

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o && $past(drive_o) && !$fell(busy_o) && $stable(swap_i) && $stable(twos_i))
            |-> $stable(bus_o));
endmodule

// File: tb/adc_pread_port_bench.sv
`timescale 1ns/1ps
module adc_pread_port_bench;
    localparam int CONV = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [15:0] sample_i;
    logic        ser_sel_i, cs_n_i, rd_n_i, swap_i, twos_i;
    logic        busy_o, drive_o;
    logic [15:0] bus_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;

    adc_pread_port #(.WIDTH(16), .CONV_CYCLES(CONV)) u_adc_pread_port (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_i(sample_i),
        .ser_sel_i(ser_sel_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
        .swap_i(swap_i), .twos_i(twos_i), .busy_o(busy_o),
        .drive_o(drive_o), .bus_o(bus_o)
    );

    function automatic logic [15:0] exp_word(input logic [15:0] raw, input logic sw, input logic tw);
        logic [15:0] c;
        c = tw ? {~raw[15], raw[14:0]} : raw;
        return sw ? {c[7:0], c[15:8]} : c;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected results as conversions complete.
    logic prev_busy = 1'b0;
    int   busy_len  = 0;
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (busy_o) busy_len++;
            if (prev_busy && !busy_o) begin
                logic [15:0] raw;
                check("R3 busy length", 16'(busy_len), 16'(CONV));
                if (exp_q.size() == 0) begin
                    check("R5 unexpected result", 16'h1, 16'h0);
                end else begin
                    raw = exp_q.pop_front();
                    if (!cs_n_i && !rd_n_i && !ser_sel_i)
                        check("R5/R11 new data at busy fall", bus_o, exp_word(raw, swap_i, twos_i));
                    else
                        check("R1 released at busy fall", 16'(drive_o), 16'h0);
                end
                busy_len = 0;
            end
            prev_busy = busy_o;
        end
    end

    // Driver: runs one conversion and pushes the expected result.
    task automatic run_conv(input logic [15:0] raw, input logic [15:0] prev, input logic extra);
        @(negedge clk);
        sample_i = raw;
        start_i  = 1'b1;
        exp_q.push_back(raw);
        @(negedge clk);
        start_i  = extra;
        sample_i = ~raw;
        @(negedge clk);
        start_i  = 1'b0;
        #1;
        check("R3 busy during conversion", 16'(busy_o), 16'h1);
        if (drive_o)
            check("R6 previous data during conversion", bus_o, exp_word(prev, swap_i, twos_i));
        while (busy_o) @(negedge clk);
        #2;
        @(negedge clk);
        #1;
        check("R4 no restart after conversion", 16'(busy_o), 16'h0);
    endtask

    initial begin
        rst_n = 1'b0; start_i = 1'b0; sample_i = '0;
        ser_sel_i = 1'b0; cs_n_i = 1'b1; rd_n_i = 1'b1; swap_i = 1'b0; twos_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R10 busy after reset", 16'(busy_o), 16'h0);
        check("R1 released with cs high", 16'(drive_o), 16'h0);
        cs_n_i = 1'b0; rd_n_i = 1'b0; #1;
        check("R1 driving with strobes low", 16'(drive_o), 16'h1);
        check("R10 reset result straight", bus_o, 16'h0000);
        twos_i = 1'b1; #1;
        check("R10 reset result twos", bus_o, 16'h8000);
        twos_i = 1'b0;
        ser_sel_i = 1'b1; #1;
        check("R2 serial mode releases bus", 16'(drive_o), 16'h0);
        ser_sel_i = 1'b0; rd_n_i = 1'b1; #1;
        check("R1 released with rd high", 16'(drive_o), 16'h0);
        rd_n_i = 1'b0;

        // R11 continuous read, R4 extra start during busy
        run_conv(16'h1234, 16'h0000, 1'b1);
        swap_i = 1'b0; twos_i = 1'b0; #1;
        check("R7 natural lanes", bus_o, 16'h1234);
        swap_i = 1'b1; #1;
        check("R8 swapped lanes", bus_o, 16'h3412);
        twos_i = 1'b1; #1;
        check("R8 R9 swapped twos", bus_o, 16'h3492);
        swap_i = 1'b0; #1;
        check("R9 twos coding", bus_o, 16'h9234);

        run_conv(16'hA5C3, 16'h1234, 1'b0);
        swap_i = 1'b1; twos_i = 1'b0;
        run_conv(16'h00FF, 16'hA5C3, 1'b0);
        twos_i = 1'b1;
        run_conv(16'h8001, 16'h00FF, 1'b1);
        #1;
        check("R9 twos of 8001", bus_o, 16'h0100);

        // read after conversion: bus released during conversion
        swap_i = 1'b0; twos_i = 1'b0; cs_n_i = 1'b1;
        run_conv(16'hFFFF, 16'h8001, 1'b0);
        check("R1 released while deselected", 16'(drive_o), 16'h0);
        cs_n_i = 1'b0; #1;
        check("R7 read after conversion", bus_o, 16'hFFFF);

        repeat (2) @(negedge clk);
        check("R5 queue drained", 16'(exp_q.size()), 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule